// File: doc/BRIEF.md
# Stack Instruction Group Former

This block sits between an instruction decoder and a fixed multistage execution pipeline. It receives one decoded stack instruction per cycle, given as a class code and a byte length. It packs runs of consecutive instructions into a single group that the pipeline can carry through its stages together. Short stack operations each do very little work, so fusing them lets one pipeline slot do the work of several of them.

Every pipeline stage has a fixed budget. An instruction joins the open group only if the group stays within every budget with it added. The budgets cover total bytes, workspace-local reads, non-local address computations, data cache reads, arithmetic operations and memory writes. A control-flow instruction is always the last member of its group.

Each closed group is handed out as a descriptor under a valid/ready handshake. The descriptor carries:
- the instruction count;
- the total byte length, which the fetch side uses to advance its pointer;
- the class of each member, in order;
- the totals of the resources the group uses.

Top module: `grp_former`

## Requirements
- R1: The byte lengths of the members of a group add up to at most MAX_BYTES (8). A group that sums to exactly 8 is allowed. `in_len_i` holds the instruction's byte count, from 1 to 8.
- R2: A group holds at most two workspace-local reads. Class 1 (local load) uses one.
- R3: A group holds at most two non-local address computations and at most two data cache reads. Class 3 (non-local load) uses one of each. Class 4 (non-local pointer) uses one address computation. Class 5 (non-local store) uses one address computation and one write.
- R4: A group holds at most one arithmetic operation and at most one memory write. Class 6 (operate) uses one arithmetic operation. Class 2 (local store) uses one write. Class 0 (constant) uses no resource.
- R5: Instructions are grouped strictly in order. If an instruction would break any budget, it closes the open group and starts the next one. The sequence local load, local load, operate forms a single group.
- R6: A class 7 (jump) instruction is the last member of its group. If a jump does not fit in the open group, the group is emitted without it and the jump then forms a group of its own.
- R7: The descriptor holds the count, the total length, and the member classes in `grp_cls_o`. The class of slot i sits at bits [3i+2:3i], slot 0 is the oldest member, and unused slots are zero. The descriptor also holds the resource totals of the group.
- R8: If the input is not valid while a group is open and the output can take a descriptor, the partial group is presented on the output after the next clock edge.
- R9: While the output is valid and not accepted, the descriptor stays stable and `in_ready_o` is low. No instruction is lost or duplicated across the stall.
- R10: After reset the output is not valid and `in_ready_o` is high.
- R11: A group holds between 1 and MAX_INSNS (8) instructions. Eight one-byte instructions form one group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Decoded instruction valid |
| in_ready_o | output | 1 | Instruction accepted when high with valid |
| in_cls_i | input | 3 | Instruction class code |
| in_len_i | input | LEN_W | Instruction byte length |
| out_valid_o | output | 1 | Group descriptor valid |
| out_ready_i | input | 1 | Downstream accepts descriptor |
| grp_cnt_o | output | CNT_W | Number of instructions in group |
| grp_len_o | output | LEN_W | Total byte length of group |
| grp_cls_o | output | 3*MAX_INSNS | Member classes, slot 0 in low bits |
| grp_lr_o | output | UW | Local reads used |
| grp_ac_o | output | UW | Address computations used |
| grp_cr_o | output | UW | Cache reads used |
| grp_alu_o | output | UW | Arithmetic operations used |
| grp_wr_o | output | UW | Memory writes used |

## Verification
The bench drives each budget up to its limit and then one step past it.
- If a design compares budgets off by one, it either rejects a group that sums to exactly eight bytes or admits a third local read.
- If a design drops the instruction that overflows a group instead of starting the next group with it, the groups that follow come out one short.
- A jump that does not fit is a separate case. If the design merges the jump into the next group, or loses it, the expected three-group split does not appear.

The bench also stalls the output while a new instruction is waiting. A design that lets the held descriptor change would be caught, and so would one that takes the waiting instruction twice or not at all. Finally, the bench checks the exact cycle in which a partial group is flushed when the input runs dry.

// File: rtl/grp_pkg.sv
package grp_pkg;
  localparam int CLS_W   = 3;
  localparam int NUM_USE = 5;
  localparam int U_LR    = 0;
  localparam int U_AC    = 1;
  localparam int U_CR    = 2;
  localparam int U_ALU   = 3;
  localparam int U_WR    = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_CONST = 3'd0,
    CL_LDL   = 3'd1,
    CL_STL   = 3'd2,
    CL_LDNL  = 3'd3,
    CL_NLPTR = 3'd4,
    CL_STNL  = 3'd5,
    CL_OPR   = 3'd6,
    CL_JUMP  = 3'd7
  } ins_cls_e;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_ADD,
    ACC_LOAD,
    ACC_CLEAR
  } acc_op_e;

  typedef logic [NUM_USE-1:0] use_vec_t;

  function automatic use_vec_t cls_use(input ins_cls_e c);
    use_vec_t u;
    u = '0;
    case (c)
      CL_LDL:   u[U_LR] = 1'b1;
      CL_STL:   u[U_WR] = 1'b1;
      CL_LDNL:  begin u[U_AC] = 1'b1; u[U_CR] = 1'b1; end
      CL_NLPTR: u[U_AC] = 1'b1;
      CL_STNL:  begin u[U_AC] = 1'b1; u[U_WR] = 1'b1; end
      CL_OPR:   u[U_ALU] = 1'b1;
      default:  ;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/grp_budget.sv
module grp_budget import grp_pkg::*; #(
  parameter int unsigned MAX_BYTES = 8,
  parameter int unsigned MAX_INSNS = 8,
  parameter int unsigned USE_MAX [NUM_USE] = '{2, 2, 2, 1, 1},
  parameter int LEN_W = 4,
  parameter int CNT_W = 4,
  parameter int UW    = 2
) (
  input  logic [CNT_W-1:0]            acc_cnt_i,
  input  logic [LEN_W-1:0]            acc_len_i,
  input  logic [NUM_USE-1:0][UW-1:0]  acc_use_i,
  input  logic [LEN_W-1:0]            in_len_i,
  input  use_vec_t                    in_use_i,
  output logic                        fits_o
);
  logic [LEN_W:0]       len_sum;
  logic [NUM_USE-1:0]   use_ok;

  assign len_sum = {1'b0, acc_len_i} + {1'b0, in_len_i};

  for (genvar k = 0; k < NUM_USE; k++) begin : g_use
    logic [UW:0] s;
    assign s         = {1'b0, acc_use_i[k]} + (UW+1)'(in_use_i[k]);
    assign use_ok[k] = (s <= (UW+1)'(USE_MAX[k]));
  end

  assign fits_o = (len_sum <= (LEN_W+1)'(MAX_BYTES))
               && (acc_cnt_i < CNT_W'(MAX_INSNS))
               && (&use_ok);
endmodule

// File: rtl/grp_accum.sv
module grp_accum import grp_pkg::*; #(
  parameter int unsigned MAX_INSNS = 8,
  parameter int LEN_W = 4,
  parameter int CNT_W = 4,
  parameter int UW    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  acc_op_e                       op_i,
  input  logic                          seal_i,
  input  logic [CLS_W-1:0]              in_cls_i,
  input  logic [LEN_W-1:0]              in_len_i,
  input  use_vec_t                      in_use_i,
  output logic [CNT_W-1:0]              acc_cnt_o,
  output logic [LEN_W-1:0]              acc_len_o,
  output logic [NUM_USE-1:0][UW-1:0]    acc_use_o,
  output logic [MAX_INSNS*CLS_W-1:0]    acc_cls_o,
  output logic                          acc_seal_o,
  output logic [CNT_W-1:0]              sum_cnt_o,
  output logic [LEN_W-1:0]              sum_len_o,
  output logic [NUM_USE-1:0][UW-1:0]    sum_use_o,
  output logic [MAX_INSNS*CLS_W-1:0]    sum_cls_o
);
  logic [NUM_USE-1:0][UW-1:0]  one_use;
  logic [MAX_INSNS*CLS_W-1:0]  one_cls;

  assign sum_cnt_o = acc_cnt_o + CNT_W'(1);
  assign sum_len_o = acc_len_o + in_len_i;

  for (genvar k = 0; k < NUM_USE; k++) begin : g_use
    assign sum_use_o[k] = acc_use_o[k] + UW'(in_use_i[k]);
    assign one_use[k]   = UW'(in_use_i[k]);
  end

  // new member lands in the first free slot
  for (genvar s = 0; s < MAX_INSNS; s++) begin : g_slot
    assign sum_cls_o[s*CLS_W +: CLS_W] =
      (acc_cnt_o == CNT_W'(s)) ? in_cls_i : acc_cls_o[s*CLS_W +: CLS_W];
    if (s == 0) begin : g_head
      assign one_cls[s*CLS_W +: CLS_W] = in_cls_i;
    end else begin : g_tail
      assign one_cls[s*CLS_W +: CLS_W] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt_o  <= '0;
      acc_len_o  <= '0;
      acc_use_o  <= '0;
      acc_cls_o  <= '0;
      acc_seal_o <= 1'b0;
    end else begin
      case (op_i)
        ACC_ADD: begin
          acc_cnt_o <= sum_cnt_o;
          acc_len_o <= sum_len_o;
          acc_use_o <= sum_use_o;
          acc_cls_o <= sum_cls_o;
        end
        ACC_LOAD: begin
          acc_cnt_o  <= CNT_W'(1);
          acc_len_o  <= in_len_i;
          acc_use_o  <= one_use;
          acc_cls_o  <= one_cls;
          acc_seal_o <= seal_i;
        end
        ACC_CLEAR: begin
          acc_cnt_o  <= '0;
          acc_len_o  <= '0;
          acc_use_o  <= '0;
          acc_cls_o  <= '0;
          acc_seal_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_acc_count_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_cnt_o <= CNT_W'(MAX_INSNS));
endmodule

// File: rtl/grp_out.sv
module grp_out import grp_pkg::*; #(
  parameter int unsigned MAX_BYTES = 8,
  parameter int unsigned MAX_INSNS = 8,
  parameter int unsigned USE_MAX [NUM_USE] = '{2, 2, 2, 1, 1},
  parameter int LEN_W = 4,
  parameter int CNT_W = 4,
  parameter int UW    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        ready_i,
  input  logic [CNT_W-1:0]            d_cnt_i,
  input  logic [LEN_W-1:0]            d_len_i,
  input  logic [NUM_USE-1:0][UW-1:0]  d_use_i,
  input  logic [MAX_INSNS*CLS_W-1:0]  d_cls_i,
  output logic                        valid_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [LEN_W-1:0]            len_o,
  output logic [NUM_USE-1:0][UW-1:0]  use_o,
  output logic [MAX_INSNS*CLS_W-1:0]  cls_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cnt_o   <= '0;
      len_o   <= '0;
      use_o   <= '0;
      cls_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      cnt_o   <= d_cnt_i;
      len_o   <= d_len_i;
      use_o   <= d_use_i;
      cls_o   <= d_cls_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_byte_budget_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> len_o <= LEN_W'(MAX_BYTES));

  assert_group_size_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cnt_o != '0) && (cnt_o <= CNT_W'(MAX_INSNS)));

  // index 0: R2, indices 1-2: R3, indices 3-4: R4
  for (genvar k = 0; k < NUM_USE; k++) begin : g_chk
    assert_use_budget_R2_R3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> use_o[k] <= UW'(USE_MAX[k]));
  end
endmodule

// File: rtl/grp_former.sv
module grp_former import grp_pkg::*; #(
  parameter int unsigned MAX_BYTES = 8,
  parameter int unsigned MAX_INSNS = 8,
  parameter int unsigned LR_MAX    = 2,
  parameter int unsigned AC_MAX    = 2,
  parameter int unsigned CR_MAX    = 2,
  parameter int unsigned ALU_MAX   = 1,
  parameter int unsigned WR_MAX    = 1,
  parameter int LEN_W = $clog2(MAX_BYTES + 1),
  parameter int CNT_W = $clog2(MAX_INSNS + 1),
  parameter int UW    = $clog2(((LR_MAX > AC_MAX ? LR_MAX : AC_MAX) > CR_MAX ?
                                (LR_MAX > AC_MAX ? LR_MAX : AC_MAX) : CR_MAX) + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [2:0]                  in_cls_i,
  input  logic [LEN_W-1:0]            in_len_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [CNT_W-1:0]            grp_cnt_o,
  output logic [LEN_W-1:0]            grp_len_o,
  output logic [MAX_INSNS*3-1:0]      grp_cls_o,
  output logic [UW-1:0]               grp_lr_o,
  output logic [UW-1:0]               grp_ac_o,
  output logic [UW-1:0]               grp_cr_o,
  output logic [UW-1:0]               grp_alu_o,
  output logic [UW-1:0]               grp_wr_o
);
  localparam int unsigned USE_MAX [NUM_USE] = '{LR_MAX, AC_MAX, CR_MAX, ALU_MAX, WR_MAX};

  ins_cls_e                    cls;
  use_vec_t                    in_use;
  logic                        fits, can_emit, take, flush, is_jmp, nonempty;
  logic                        emit, emit_sum, seal;
  acc_op_e                     acc_op;

  logic [CNT_W-1:0]            acc_cnt, sum_cnt;
  logic [LEN_W-1:0]            acc_len, sum_len;
  logic [NUM_USE-1:0][UW-1:0]  acc_use, sum_use, out_use;
  logic [MAX_INSNS*CLS_W-1:0]  acc_cls, sum_cls;
  logic                        acc_seal;

  assign cls      = ins_cls_e'(in_cls_i);
  assign in_use   = cls_use(cls);
  assign is_jmp   = (cls == CL_JUMP);
  assign nonempty = (acc_cnt != '0);
  assign can_emit = !out_valid_o || out_ready_i;
  assign in_ready_o = can_emit;
  assign take     = in_valid_i && can_emit;
  // sealed jump, dry input or budget overflow all close the open group
  assign flush    = nonempty && can_emit && (acc_seal || !in_valid_i || !fits);

  always_comb begin
    acc_op   = ACC_HOLD;
    seal     = 1'b0;
    emit     = 1'b0;
    emit_sum = 1'b0;
    if (take && is_jmp && !flush) begin
      emit     = 1'b1;
      emit_sum = 1'b1;
      acc_op   = ACC_CLEAR;
    end else if (flush) begin
      emit = 1'b1;
      if (take) begin
        acc_op = ACC_LOAD;
        seal   = is_jmp;
      end else begin
        acc_op = ACC_CLEAR;
      end
    end else if (take) begin
      acc_op = ACC_ADD;
    end
  end

  grp_budget #(
    .MAX_BYTES(MAX_BYTES), .MAX_INSNS(MAX_INSNS), .USE_MAX(USE_MAX),
    .LEN_W(LEN_W), .CNT_W(CNT_W), .UW(UW)
  ) i_budget (
    .acc_cnt_i (acc_cnt),
    .acc_len_i (acc_len),
    .acc_use_i (acc_use),
    .in_len_i  (in_len_i),
    .in_use_i  (in_use),
    .fits_o    (fits)
  );

  grp_accum #(
    .MAX_INSNS(MAX_INSNS), .LEN_W(LEN_W), .CNT_W(CNT_W), .UW(UW)
  ) i_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (acc_op),
    .seal_i     (seal),
    .in_cls_i   (in_cls_i),
    .in_len_i   (in_len_i),
    .in_use_i   (in_use),
    .acc_cnt_o  (acc_cnt),
    .acc_len_o  (acc_len),
    .acc_use_o  (acc_use),
    .acc_cls_o  (acc_cls),
    .acc_seal_o (acc_seal),
    .sum_cnt_o  (sum_cnt),
    .sum_len_o  (sum_len),
    .sum_use_o  (sum_use),
    .sum_cls_o  (sum_cls)
  );

  grp_out #(
    .MAX_BYTES(MAX_BYTES), .MAX_INSNS(MAX_INSNS), .USE_MAX(USE_MAX),
    .LEN_W(LEN_W), .CNT_W(CNT_W), .UW(UW)
  ) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emit),
    .ready_i (out_ready_i),
    .d_cnt_i (emit_sum ? sum_cnt : acc_cnt),
    .d_len_i (emit_sum ? sum_len : acc_len),
    .d_use_i (emit_sum ? sum_use : acc_use),
    .d_cls_i (emit_sum ? sum_cls : acc_cls),
    .valid_o (out_valid_o),
    .cnt_o   (grp_cnt_o),
    .len_o   (grp_len_o),
    .use_o   (out_use),
    .cls_o   (grp_cls_o)
  );

  assign grp_lr_o  = out_use[U_LR];
  assign grp_ac_o  = out_use[U_AC];
  assign grp_cr_o  = out_use[U_CR];
  assign grp_alu_o = out_use[U_ALU];
  assign grp_wr_o  = out_use[U_WR];

  assert_dry_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonempty && !in_valid_i && can_emit |=> out_valid_o);

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(grp_len_o)
                                   && $stable(grp_cnt_o) && $stable(grp_cls_o));

  assert_reset_idle_R10: assert property (@(posedge clk_i)
    !rst_ni |=> !out_valid_o);
endmodule

// File: tb/test_grp_former.sv
module test_grp_former;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_cls = '0;
  logic [3:0]  in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  grp_cnt;
  logic [3:0]  grp_len;
  logic [23:0] grp_cls;
  logic [1:0]  grp_lr, grp_ac, grp_cr, grp_alu, grp_wr;

  always #5 clk = ~clk;

  grp_former i_grp_former (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_cls_i(in_cls), .in_len_i(in_len),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .grp_cnt_o(grp_cnt), .grp_len_o(grp_len), .grp_cls_o(grp_cls),
    .grp_lr_o(grp_lr), .grp_ac_o(grp_ac), .grp_cr_o(grp_cr),
    .grp_alu_o(grp_alu), .grp_wr_o(grp_wr)
  );

  // instruction word {cls[2:0], len[3:0]}; group word {cnt[3:0], len[3:0]}
  typedef struct packed {
    logic [3:0]      n_ins;
    logic [0:7][6:0] ins;
    logic [1:0]      n_grp;
    logic [0:3][7:0] grp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd3, {7'h11, 7'h11, 7'h61, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd1, {8'h33, 8'h00, 8'h00, 8'h00}},
    '{4'd3, {7'h11, 7'h11, 7'h11, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h22, 8'h11, 8'h00, 8'h00}},
    '{4'd3, {7'h31, 7'h31, 7'h31, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h22, 8'h11, 8'h00, 8'h00}},
    '{4'd3, {7'h42, 7'h42, 7'h42, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h24, 8'h12, 8'h00, 8'h00}},
    '{4'd2, {7'h61, 7'h61, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h11, 8'h11, 8'h00, 8'h00}},
    '{4'd2, {7'h22, 7'h51, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h12, 8'h11, 8'h00, 8'h00}},
    '{4'd3, {7'h04, 7'h04, 7'h01, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h28, 8'h11, 8'h00, 8'h00}},
    '{4'd3, {7'h11, 7'h72, 7'h11, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h23, 8'h11, 8'h00, 8'h00}},
    '{4'd3, {7'h07, 7'h72, 7'h11, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd3, {8'h17, 8'h12, 8'h11, 8'h00}},
    '{4'd8, {7'h01, 7'h01, 7'h01, 7'h01, 7'h01, 7'h01, 7'h01, 7'h01}, 2'd1, {8'h88, 8'h00, 8'h00, 8'h00}},
    '{4'd4, {7'h03, 7'h12, 7'h13, 7'h01, 7'h00, 7'h00, 7'h00, 7'h00}, 2'd2, {8'h38, 8'h11, 8'h00, 8'h00}}
  };

  function automatic string vreq(input int i);
    case (i)
      0:       return "R5";
      1:       return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6, 10:   return "R1";
      7, 8:    return "R6";
      default: return "R11";
    endcase
  endfunction

  int n_chk = 0;
  int n_fail = 0;
  int got_n = 0;
  logic [3:0]  got_cnt [16];
  logic [3:0]  got_len [16];
  logic [23:0] got_cls [16];
  logic [1:0]  got_lr [16], got_ac [16], got_cr [16], got_alu [16], got_wr [16];

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && got_n < 16) begin
      got_cnt[got_n] = grp_cnt;
      got_len[got_n] = grp_len;
      got_cls[got_n] = grp_cls;
      got_lr[got_n]  = grp_lr;
      got_ac[got_n]  = grp_ac;
      got_cr[got_n]  = grp_cr;
      got_alu[got_n] = grp_alu;
      got_wr[got_n]  = grp_wr;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] w);
    in_valid = 1'b1;
    in_cls   = w[6:4];
    in_len   = w[3:0];
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic run_all;
    // R10 reset state
    repeat (3) tick();
    chk("R10 out_valid", 32'(out_valid), 32'd0);
    chk("R10 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    tick();
    chk("R10 idle after release", 32'(out_valid), 32'd0);

    // table walk, output always ready
    for (int v = 0; v < NV; v++) begin
      got_n = 0;
      for (int k = 0; k < int'(VECS[v].n_ins); k++) begin
        drive(VECS[v].ins[k]);
        tick();
      end
      in_valid = 1'b0;
      repeat (5) tick();
      chk({vreq(v), " group count"}, 32'(got_n), 32'(VECS[v].n_grp));
      for (int g = 0; g < int'(VECS[v].n_grp); g++) begin
        chk({vreq(v), " cnt"}, 32'(got_cnt[g]), 32'(VECS[v].grp[g][7:4]));
        chk({vreq(v), " len"}, 32'(got_len[g]), 32'(VECS[v].grp[g][3:0]));
      end
      if (v == 0) begin
        // R7 slot order LDL, LDL, OPR -> 6<<6 | 1<<3 | 1
        chk("R7 class list", 32'(got_cls[0]), 32'h189);
        chk("R7 local reads", 32'(got_lr[0]), 32'd2);
        chk("R7 alu ops", 32'(got_alu[0]), 32'd1);
        chk("R7 writes", 32'(got_wr[0]), 32'd0);
      end
      if (v == 2) begin
        chk("R3 addr comps", 32'(got_ac[0]), 32'd2);
        chk("R3 cache reads", 32'(got_cr[0]), 32'd2);
      end
      if (v == 8) begin
        chk("R6 lone jump class", 32'(got_cls[1]), 32'h7);
      end
    end

    // R8 partial group appears one edge after input runs dry
    drive(7'h11);
    tick();
    in_valid = 1'b0;
    chk("R8 not yet out", 32'(out_valid), 32'd0);
    tick();
    chk("R8 flushed valid", 32'(out_valid), 32'd1);
    chk("R8 flushed cnt", 32'(grp_cnt), 32'd1);
    chk("R8 flushed len", 32'(grp_len), 32'd1);
    repeat (2) tick();

    // R9 stall with an instruction waiting
    got_n = 0;
    out_ready = 1'b0;
    drive(7'h61);
    tick();
    drive(7'h21);
    tick();
    in_valid = 1'b0;
    tick();
    chk("R9 held valid", 32'(out_valid), 32'd1);
    drive(7'h11);
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R9 stall valid", 32'(out_valid), 32'd1);
      chk("R9 stall len", 32'(grp_len), 32'd2);
      chk("R9 stall ready low", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
    repeat (4) tick();
    chk("R9 group count", 32'(got_n), 32'd2);
    chk("R9 first group", {24'd0, got_cnt[0], got_len[0]}, 32'h22);
    chk("R9 first alu+wr", {28'd0, got_alu[0], got_wr[0]}, 32'h5);
    chk("R9 waiting insn kept", {24'd0, got_cnt[1], got_len[1]}, 32'h11);
    chk("R9 waiting insn class", 32'(got_lr[1]), 32'd1);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 1'b0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule